// File: doc/BRIEF.md
# Flash Security Lockout Controller

This block decides, while the chip is held in reset, whether the part will run secured or unsecured, and from then on drives a single gate that stops the debug port from reading on-chip memory whenever the part is secured. Normal program execution is not touched by this gate. Boundary scan and the identification register stay reachable in both modes, because the block gates only debug memory reads and leaves the scan path alone.

The block also runs a recovery sequence that wipes the whole flash and so removes security. The debug logic first selects the recovery instruction and loads a 7-bit divider value N. The block then accepts a start request, runs a bulk erase timed by a tick that fires every N+1 clocks, and, after 1024 ticks, reports completion and drops the read gate at once. It does not wait for another reset to do this. The TAP state machine, the flash array and the core debug logic are outside this block. The block only sees decoded instruction and data-register strobes and drives an erase request and tick into a flash stub.

The controller is a three-state machine:
- `S_IDLE` waits for requests.
- `S_WIPE` runs the erase.
- `S_CLOSE` is a one-cycle completion state.

It has four transitions:
- `T_ACCEPT` goes from `S_IDLE` to `S_WIPE` on a valid start.
- `T_LAST_TICK` goes from `S_WIPE` to `S_CLOSE` on the 1024th tick.
- `T_RETIRE` goes from `S_CLOSE` to `S_IDLE` unconditionally.
- `T_ABORT` goes from any state to `S_IDLE` on reset.

Top module: `flash_lock_ctrl`

## Requirements
- R1: On every clock edge with `rst_n` low, the block samples `sec_byte`. The value 8'hFF selects unsecured mode (`dbg_rd_block`=0, `secure_mode`=0). Any other value selects secure mode (both outputs 1).
- R2: After reset, `dbg_rd_block` keeps its value whatever `sec_byte` does. It never rises without a reset, and it falls only in the cycle in which `done` is high.
- R3: The divider value N is captured from `dr_value` only at a clock edge where `rcv_sel` and `dr_load` are both 1 and the block is idle. A `dr_load` with `rcv_sel` at 0 leaves N unchanged.
- R4: A start request is a clock edge with `rcv_sel`=1 and `rcv_start`=1. If N was never loaded, or is 0, the request starts no erase and sets `err` to 1. An accepted start clears `err`.
- R5: `rcv_start` with `rcv_sel`=0 starts no erase and leaves `err` unchanged.
- R6: During an erase, `erase_tick` is high for one cycle in every N+1. The first tick comes in the (N+1)th busy cycle, and no tick occurs outside busy.
- R7: `busy` and `erase_req` go high in the cycle after the accepting edge. They stay high for exactly 1024*(N+1) cycles, during which exactly 1024 ticks occur.
- R8: `done` is high for exactly one cycle, the cycle right after `busy` falls. In that cycle `dbg_rd_block` and `secure_mode` are already 0.
- R9: A start request or divider load during an erase is ignored: the erase length does not change and `err` stays 0.
- R10: Reset during an erase aborts it. `busy` goes to 0, no `done` is produced, and the security state is latched again from the unchanged flash byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_byte | input | 8 | Security byte read from flash |
| rcv_sel | input | 1 | Recovery instruction is selected |
| dr_load | input | 1 | Update strobe for the 7-bit divider register |
| dr_value | input | 7 | Shifted divider value N |
| rcv_start | input | 1 | Recovery start request |
| dbg_rd_block | output | 1 | Blocks debug-port reads of internal memory |
| erase_req | output | 1 | Bulk erase request to flash |
| erase_tick | output | 1 | Erase timing tick, once every N+1 clocks |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle erase completion pulse |
| err | output | 1 | Last start request was refused for an invalid divider |
| secure_mode | output | 1 | Current mode, 1 = secure |

## Verification
The assertions check several rules on every cycle:
- The read gate only ever falls together with the completion pulse, and never rises outside reset.
- Ticks occur only while busy.
- The completion pulse lasts one cycle and directly follows busy.
- The error flag is clear for the whole of an erase.

Other behaviour can only be shown by the bench's scenarios:
- The reset-time decoding of particular byte values.
- The exact erase length of 1024*(N+1) cycles and the tick spacing for several values of N.
- The refusal of starts with no divider or a zero divider.
- The blindness to requests and divider loads during an erase.
- An aborted erase leaving the part secured.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WIPE  = 2'd1,
        S_CLOSE = 2'd2
    } lock_state_t;

endpackage

// File: rtl/flash_lock_seclatch.sv
module flash_lock_seclatch #(
    parameter int          SEC_W     = 8,
    parameter logic [7:0]  OPEN_CODE = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sec_byte,
    input  logic             wipe_clr,
    output logic             secure
);

    localparam logic [SEC_W-1:0] OPEN_VAL = SEC_W'(OPEN_CODE);

    // Decision is re-sampled on every reset cycle and frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            secure <= (sec_byte != OPEN_VAL);
        else if (wipe_clr)
            secure <= 1'b0;
    end

endmodule

// File: rtl/flash_lock_clkdiv.sv
module flash_lock_clkdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q == div_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == div_n);

endmodule

// File: rtl/flash_lock_fsm.sv
module flash_lock_fsm
    import flash_lock_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int ERASE_TICKS = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rcv_sel,
    input  logic             dr_load,
    input  logic [DIV_W-1:0] dr_value,
    input  logic             rcv_start,
    input  logic             tick,
    output logic [DIV_W-1:0] div_n,
    output logic             run,
    output logic             last_tick,
    output logic             done,
    output logic             err
);

    localparam int TC_W = (ERASE_TICKS > 1) ? $clog2(ERASE_TICKS) : 1;
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(ERASE_TICKS - 1);

    lock_state_t      state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic             div_ok_q;
    logic [TC_W-1:0]  tc_q;
    logic             idle, req, div_good, accept, refuse;

    assign idle     = (state_q == S_IDLE);
    assign req      = rcv_sel && rcv_start;
    assign div_good = div_ok_q && (div_q != '0);
    assign accept   = idle && req && div_good;
    assign refuse   = idle && req && !div_good;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept)    state_d = S_WIPE;
            S_WIPE:  if (last_tick) state_d = S_CLOSE;
            S_CLOSE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        run       = 1'b0;
        done      = 1'b0;
        last_tick = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_WIPE: begin
                run       = 1'b1;
                last_tick = tick && (tc_q == TC_LAST);
            end
            S_CLOSE: done = 1'b1;
            default: ;
        endcase
    end

    // Divider register: loaded only while idle under the recovery instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            div_ok_q <= 1'b0;
        end else if (idle && rcv_sel && dr_load) begin
            div_q    <= dr_value;
            div_ok_q <= 1'b1;
        end
    end

    // Tick counter for the erase interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            tc_q <= '0;
        else if (tick)
            tc_q <= tc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (accept)
            err <= 1'b0;
        else if (refuse)
            err <= 1'b1;
    end

    assign div_n = div_q;

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl #(
    parameter int         SEC_W       = 8,
    parameter logic [7:0] OPEN_CODE   = 8'hFF,
    parameter int         DIV_W       = 7,
    parameter int         ERASE_TICKS = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sec_byte,
    input  logic             rcv_sel,
    input  logic             dr_load,
    input  logic [DIV_W-1:0] dr_value,
    input  logic             rcv_start,
    output logic             dbg_rd_block,
    output logic             erase_req,
    output logic             erase_tick,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             secure_mode
);

    logic [DIV_W-1:0] div_n;
    logic             run, tick, last_tick, secure;

    flash_lock_seclatch #(
        .SEC_W     (SEC_W),
        .OPEN_CODE (OPEN_CODE)
    ) u_seclatch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_byte (sec_byte),
        .wipe_clr (last_tick),
        .secure   (secure)
    );

    flash_lock_clkdiv #(
        .DIV_W (DIV_W)
    ) u_clkdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div_n (div_n),
        .tick  (tick)
    );

    flash_lock_fsm #(
        .DIV_W       (DIV_W),
        .ERASE_TICKS (ERASE_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rcv_sel   (rcv_sel),
        .dr_load   (dr_load),
        .dr_value  (dr_value),
        .rcv_start (rcv_start),
        .tick      (tick),
        .div_n     (div_n),
        .run       (run),
        .last_tick (last_tick),
        .done      (done),
        .err       (err)
    );

    assign dbg_rd_block = secure;
    assign secure_mode  = secure;
    assign busy         = run;
    assign erase_req    = run;
    assign erase_tick   = tick;

endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic dbg_rd_block,
    input logic erase_tick,
    input logic busy,
    input logic done,
    input logic err
);

    // R2
    gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(dbg_rd_block)) |-> done);

    // R2
    gate_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$rose(dbg_rd_block));

    // R6
    tick_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_tick |-> busy);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && done) |-> ($past(busy) && !busy));

    // R9
    err_clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !err);

endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_rd_block (dbg_rd_block),
    .erase_tick   (erase_tick),
    .busy         (busy),
    .done         (done),
    .err          (err)
);

// File: tb/flash_lock_ctrl_bench.sv
`timescale 1ns/1ps
module flash_lock_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] prog_byte = 8'h00;
    logic       prog_req = 1'b0;
    logic       stub_erased = 1'b0;
    logic [7:0] sec_byte;
    logic       rcv_sel = 1'b0, dr_load = 1'b0, rcv_start = 1'b0;
    logic [6:0] dr_value = '0;
    logic       dbg_rd_block, erase_req, erase_tick, busy, done, err, secure_mode;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    // Flash stub: erased by a completed recovery, reprogrammed on request.
    always @(posedge clk) begin
        if (prog_req)  stub_erased <= 1'b0;
        else if (done) stub_erased <= 1'b1;
    end
    assign sec_byte = stub_erased ? 8'hFF : prog_byte;

    flash_lock_ctrl u_flash_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .sec_byte(sec_byte), .rcv_sel(rcv_sel),
        .dr_load(dr_load), .dr_value(dr_value), .rcv_start(rcv_start),
        .dbg_rd_block(dbg_rd_block), .erase_req(erase_req), .erase_tick(erase_tick),
        .busy(busy), .done(done), .err(err), .secure_mode(secure_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic do_reset(input logic [7:0] b, input bit reprog);
        @(negedge clk);
        prog_byte = b;
        prog_req  = reprog;
        rst_n     = 1'b0;
        rcv_sel = 0; dr_load = 0; rcv_start = 0;
        repeat (3) @(negedge clk);
        prog_req = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_div(input logic [6:0] v, input logic sel);
        rcv_sel = sel; dr_load = 1'b1; dr_value = v;
        @(negedge clk);
        dr_load = 1'b0; rcv_sel = 1'b0;
    endtask

    task automatic pulse_start(input logic sel);
        rcv_sel = sel; rcv_start = 1'b1;
        @(negedge clk);
        rcv_start = 1'b0; rcv_sel = 1'b0;
    endtask

    task automatic t_reset_decode(input logic [7:0] b, input int exp_sec);
        do_reset(b, 1'b1);
        check("R1 gate", dbg_rd_block, exp_sec);
        check("R1 mode", secure_mode, exp_sec);
        check("R1 idle busy", busy, 0);
    endtask

    task automatic t_byte_change_held();
        do_reset(8'h00, 1'b1);
        prog_byte = 8'hFF;
        repeat (5) @(negedge clk);
        check("R2 gate held after byte change", dbg_rd_block, 1);
        prog_byte = 8'h00;
    endtask

    task automatic t_refusals();
        do_reset(8'h00, 1'b1);
        pulse_start(1'b1);
        check("R4 no-load start busy", busy, 0);
        check("R4 no-load start err", err, 1);
        pulse_start(1'b0);
        check("R5 unselected start busy", busy, 0);
        check("R5 unselected start err", err, 1);
        load_div(7'd0, 1'b1);
        pulse_start(1'b1);
        check("R4 zero divider busy", busy, 0);
        check("R4 zero divider err", err, 1);
        check("R4 gate kept", dbg_rd_block, 1);
    endtask

    // Runs one erase from an accepted start and checks its timing.
    task automatic run_erase(input int n, input bit poke, input string tag);
        int cnt = 0;
        int ticks = 0;
        int first = 0;
        int gaps_bad = 0;
        int last = 0;
        bit err_seen = 0;
        rcv_sel = 1'b1; rcv_start = 1'b1;
        @(negedge clk);
        rcv_start = 1'b0; rcv_sel = 1'b0;
        check({tag, " R7 busy after accept"}, busy, 1);
        check({tag, " R7 erase_req"}, erase_req, 1);
        check({tag, " R4 err cleared"}, err, 0);
        check({tag, " R2 gate during erase"}, dbg_rd_block, 1);
        while (busy && cnt < 20000) begin
            cnt++;
            if (err) err_seen = 1;
            if (erase_tick) begin
                ticks++;
                if (first == 0) first = cnt;
                else if (cnt - last != n + 1) gaps_bad++;
                last = cnt;
            end
            if (poke && cnt == 100) begin
                rcv_sel = 1; rcv_start = 1; dr_load = 1; dr_value = 7'd5;
            end else begin
                rcv_sel = 0; rcv_start = 0; dr_load = 0;
            end
            @(negedge clk);
        end
        check({tag, " R7 busy length"}, cnt, 1024 * (n + 1));
        check({tag, " R7 tick count"}, ticks, 1024);
        check({tag, " R6 first tick"}, first, n + 1);
        check({tag, " R6 tick spacing errors"}, gaps_bad, 0);
        check({tag, " R8 done pulse"}, done, 1);
        check({tag, " R8 gate open at done"}, dbg_rd_block, 0);
        check({tag, " R8 mode open at done"}, secure_mode, 0);
        if (poke) check({tag, " R9 err stays low"}, err_seen, 0);
        @(negedge clk);
        check({tag, " R8 done one cycle"}, done, 0);
        check({tag, " R2 gate stays open"}, dbg_rd_block, 0);
    endtask

    task automatic t_erase_basic();
        do_reset(8'h00, 1'b1);
        load_div(7'd1, 1'b1);
        run_erase(1, 1'b0, "N1");
    endtask

    task automatic t_erase_poked();
        do_reset(8'h3C, 1'b1);
        check("R1 reprogrammed secure", dbg_rd_block, 1);
        load_div(7'd2, 1'b1);
        run_erase(2, 1'b1, "R9 N2");
    endtask

    task automatic t_unselected_load();
        do_reset(8'h00, 1'b1);
        load_div(7'd3, 1'b1);
        load_div(7'd7, 1'b0);
        run_erase(3, 1'b0, "R3 N3");
        do_reset(8'h00, 1'b0);
        check("R1 erased flash reads open", dbg_rd_block, 0);
    endtask

    task automatic t_abort();
        int done_seen = 0;
        do_reset(8'h00, 1'b1);
        load_div(7'd1, 1'b1);
        pulse_start(1'b1);
        check("R10 started", busy, 1);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 busy dropped in reset", busy, 0);
        rst_n = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (done) done_seen++;
        end
        check("R10 no done", done_seen, 0);
        check("R10 gate still set", dbg_rd_block, 1);
        check("R10 busy after abort", busy, 0);
    endtask

    initial begin
        t_reset_decode(8'h00, 1);
        t_reset_decode(8'hFE, 1);
        t_reset_decode(8'hFF, 0);
        t_byte_change_held();
        t_refusals();
        t_erase_basic();
        t_erase_poked();
        t_unselected_load();
        t_abort();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule